// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small 8-bit accumulator machine whose registers, memory and ALU share one bus. Each clock cycle it presents one microinstruction as a 13-bit word of control pins. Every pin has a fixed idle level. The word sets every pin on every cycle, and in each cycle at most one source drives the bus while one or two destinations load from it. A microprogram counter addresses a control store held as a case table. A second table maps the 4-bit opcode from the instruction register to the first microaddress of that opcode's execute routine.

Each microinstruction carries a 2-bit sequencing field and a 5-bit target address. The sequencing field picks the next microaddress: the current address plus one, the mapped start address for the current opcode, the target address, or the fetch entry at address 0. Every instruction starts with the same three fetch steps. The third fetch step hands over to the mapped routine. The microinstruction is held in a register, so the pins come straight from flops. A one-hot ring output tells the datapath which step of the current instruction is running.

Top module: `ctl_sequencer`

## Requirements
- R1: Reset is synchronous and active high. After any clock edge with reset high, the control pins equal the idle pattern 0x0C7E and the ring output is 0. This also holds when reset arrives in the middle of an instruction. The first cycle after reset is released shows fetch step 1 with the ring at 6'b000001.
- R2: The control pins are, from bit 0 up: PC increment (asserted high), PC drive (asserted low), MAR load (low), memory drive (low), IR load (low), IR drive of its low nibble (low), accumulator load (low), accumulator drive (high), ALU subtract (high), ALU drive (high), B load (low), output load (low) and halt (high). A pin at its idle level means the signal is not asserted.
- R3: The three fetch steps are: (1) PC drive with MAR load; (2) memory drive with IR load; (3) PC increment only. The opcode is taken in step 3.
- R4: In no cycle is more than one of PC drive, memory drive, IR drive, accumulator drive and ALU drive asserted.
- R5: After fetch, the opcode selects the execute steps. Opcode 0x0 (load) runs IR→MAR, memory→accumulator, then one idle step. Opcode 0x1 (add) runs IR→MAR, memory→B, then ALU→accumulator. Opcode 0x2 (subtract) runs the same steps as add, with ALU subtract asserted in the last step.
- R6: The ring output is one-hot or zero. It moves up one position each cycle and holds at bit 5. It returns to bit 0 in the cycle in which a fetch begins.
- R7: Steps run in address order except where a step's sequencing field says otherwise. After the last execute step the sequencer returns to fetch, so the load, add and subtract opcodes each take 6 cycles.
- R8: Opcode 0xE (output) runs accumulator drive with output load. It then uses the explicit target address to skip the next store word, which asserts halt, and runs one idle step before returning. The instruction takes 5 cycles and halt is never asserted during it.
- R9: Opcode 0xF (halt) asserts halt from its first execute step onward, in every cycle. It jumps to its own address, so no further fetch begins.
- R10: Every other opcode value (0x3 to 0xD) runs exactly one all-idle step and then returns to fetch, for a total of 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| ctrl_pins | output | 13 | Control word at pin polarity, layout per R2 |
| ring | output | 6 | One-hot step indicator of the current instruction |

## Verification
The assertions take for granted that the opcode input is stable and meaningful in the third fetch step, which is the only cycle in which it is used. They check sequencing against the previous cycle's sequencing field and mapped address. The bench meets this assumption with a datapath model that loads its instruction register from the bus on the falling edge of fetch step 2. The opcode therefore settles half a cycle before the step that reads it and changes only when the next fetch reloads it. Resets are applied and released between clock edges, so the sequencer never sees a partial cycle.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  localparam int UA_W   = 5;
  localparam int OPC_W  = 4;
  localparam int RING_W = 6;
  localparam int CW_W   = 13;

  typedef logic [UA_W-1:0]  uaddr_t;
  typedef logic [CW_W-1:0]  ctl_t;
  typedef logic [OPC_W-1:0] opc_t;

  typedef enum logic [1:0] {
    NS_INC = 2'd0,
    NS_MAP = 2'd1,
    NS_JMP = 2'd2,
    NS_RET = 2'd3
  } nsel_e;

  typedef struct packed {
    ctl_t   ctl;
    nsel_e  nsel;
    uaddr_t naddr;
  } uinst_t;

  // control signals, asserted sense
  localparam ctl_t S_PC_INC  = ctl_t'(1) << 0;
  localparam ctl_t S_PC_DRV  = ctl_t'(1) << 1;
  localparam ctl_t S_MAR_LD  = ctl_t'(1) << 2;
  localparam ctl_t S_MEM_DRV = ctl_t'(1) << 3;
  localparam ctl_t S_IR_LD   = ctl_t'(1) << 4;
  localparam ctl_t S_IR_DRV  = ctl_t'(1) << 5;
  localparam ctl_t S_ACC_LD  = ctl_t'(1) << 6;
  localparam ctl_t S_ACC_DRV = ctl_t'(1) << 7;
  localparam ctl_t S_ALU_SUB = ctl_t'(1) << 8;
  localparam ctl_t S_ALU_DRV = ctl_t'(1) << 9;
  localparam ctl_t S_B_LD    = ctl_t'(1) << 10;
  localparam ctl_t S_OUT_LD  = ctl_t'(1) << 11;
  localparam ctl_t S_HALT    = ctl_t'(1) << 12;

  // pins whose idle level is high (active-low signals)
  localparam ctl_t IDLE_PINS = S_PC_DRV | S_MAR_LD | S_MEM_DRV | S_IR_LD |
                               S_IR_DRV | S_ACC_LD | S_B_LD | S_OUT_LD;
  localparam ctl_t DRIVE_MASK = S_PC_DRV | S_MEM_DRV | S_IR_DRV |
                                S_ACC_DRV | S_ALU_DRV;

  // control store layout
  localparam uaddr_t A_FETCH = uaddr_t'(0);
  localparam uaddr_t A_LOAD  = uaddr_t'(3);
  localparam uaddr_t A_ADD   = uaddr_t'(6);
  localparam uaddr_t A_SUB   = uaddr_t'(9);
  localparam uaddr_t A_OUT   = uaddr_t'(12);
  localparam uaddr_t A_HALT  = uaddr_t'(15);
  localparam uaddr_t A_UNDEF = uaddr_t'(16);

  localparam opc_t OP_LOAD = opc_t'(4'h0);
  localparam opc_t OP_ADD  = opc_t'(4'h1);
  localparam opc_t OP_SUB  = opc_t'(4'h2);
  localparam opc_t OP_OUT  = opc_t'(4'hE);
  localparam opc_t OP_HALT = opc_t'(4'hF);

  localparam uinst_t IDLE_UINST = '{ctl: '0, nsel: NS_RET, naddr: A_FETCH};
  localparam logic [RING_W-1:0] RING_FIRST = RING_W'(1);

  function automatic ctl_t pins_from_ctl(input ctl_t c);
    return c ^ IDLE_PINS;
  endfunction

  function automatic ctl_t ctl_from_pins(input ctl_t p);
    return p ^ IDLE_PINS;
  endfunction

  function automatic logic op_defined(input opc_t op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
           (op == OP_OUT)  || (op == OP_HALT);
  endfunction

  function automatic uaddr_t next_uaddr(input nsel_e sel, input uaddr_t cur,
                                        input uaddr_t mapped, input uaddr_t target);
    case (sel)
      NS_INC:  return cur + uaddr_t'(1);
      NS_MAP:  return mapped;
      NS_JMP:  return target;
      default: return A_FETCH;
    endcase
  endfunction

  function automatic logic [RING_W-1:0] ring_step(input logic [RING_W-1:0] r,
                                                  input logic restart);
    if (restart)          return RING_FIRST;
    else if (r[RING_W-1]) return r;
    else                  return r << 1;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import ctl_seq_pkg::*;
(
  input  uaddr_t addr,
  output uinst_t word
);

  function automatic uinst_t mk(input ctl_t c, input nsel_e n, input uaddr_t a);
    mk.ctl   = c;
    mk.nsel  = n;
    mk.naddr = a;
  endfunction

  always_comb begin
    case (addr)
      // fetch
      5'd0:  word = mk(S_PC_DRV | S_MAR_LD, NS_INC, A_FETCH);
      5'd1:  word = mk(S_MEM_DRV | S_IR_LD, NS_INC, A_FETCH);
      5'd2:  word = mk(S_PC_INC, NS_MAP, A_FETCH);
      // load
      5'd3:  word = mk(S_IR_DRV | S_MAR_LD, NS_INC, A_FETCH);
      5'd4:  word = mk(S_MEM_DRV | S_ACC_LD, NS_INC, A_FETCH);
      5'd5:  word = mk('0, NS_RET, A_FETCH);
      // add
      5'd6:  word = mk(S_IR_DRV | S_MAR_LD, NS_INC, A_FETCH);
      5'd7:  word = mk(S_MEM_DRV | S_B_LD, NS_INC, A_FETCH);
      5'd8:  word = mk(S_ALU_DRV | S_ACC_LD, NS_RET, A_FETCH);
      // subtract
      5'd9:  word = mk(S_IR_DRV | S_MAR_LD, NS_INC, A_FETCH);
      5'd10: word = mk(S_MEM_DRV | S_B_LD, NS_INC, A_FETCH);
      5'd11: word = mk(S_ALU_DRV | S_ALU_SUB | S_ACC_LD, NS_RET, A_FETCH);
      // output: skips word 13
      5'd12: word = mk(S_ACC_DRV | S_OUT_LD, NS_JMP, A_OUT + uaddr_t'(2));
      5'd13: word = mk(S_HALT, NS_RET, A_FETCH);
      5'd14: word = mk('0, NS_RET, A_FETCH);
      // halt: self loop
      5'd15: word = mk(S_HALT, NS_JMP, A_HALT);
      // undefined opcodes
      5'd16: word = mk('0, NS_RET, A_FETCH);
      default: word = IDLE_UINST;
    endcase
  end

endmodule

// File: rtl/useq_map.sv
module useq_map
  import ctl_seq_pkg::*;
(
  input  opc_t   op,
  output uaddr_t start
);

  always_comb begin
    case (op)
      OP_LOAD: start = A_LOAD;
      OP_ADD:  start = A_ADD;
      OP_SUB:  start = A_SUB;
      OP_OUT:  start = A_OUT;
      OP_HALT: start = A_HALT;
      default: start = A_UNDEF;
    endcase
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import ctl_seq_pkg::*;
(
  input  nsel_e  sel,
  input  uaddr_t cur,
  input  uaddr_t mapped,
  input  uaddr_t target,
  output uaddr_t nxt
);

  assign nxt = next_uaddr(sel, cur, mapped, target);

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  output logic [CW_W-1:0]   ctrl_pins,
  output logic [RING_W-1:0] ring
);

  uinst_t            uir_q;
  uaddr_t            upc_q;
  logic [RING_W-1:0] ring_q;

  // named internal events for the checker
  uaddr_t map_addr;
  uaddr_t next_addr;
  uaddr_t jump_addr;
  nsel_e  nsel_w;
  uinst_t store_word;
  logic   fetch_start;

  assign nsel_w      = uir_q.nsel;
  assign jump_addr   = uir_q.naddr;
  assign fetch_start = (uir_q.nsel == NS_RET);

  useq_map u_map (
    .op    (opcode),
    .start (map_addr)
  );

  useq_next u_next (
    .sel    (nsel_w),
    .cur    (upc_q),
    .mapped (map_addr),
    .target (jump_addr),
    .nxt    (next_addr)
  );

  useq_store u_store (
    .addr (next_addr),
    .word (store_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q  <= A_FETCH;
      uir_q  <= IDLE_UINST;
      ring_q <= '0;
    end else begin
      upc_q  <= next_addr;
      uir_q  <= store_word;
      ring_q <= ring_step(ring_q, fetch_start);
    end
  end

  assign ctrl_pins = pins_from_ctl(uir_q.ctl);
  assign ring      = ring_q;

endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk
  import ctl_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OPC_W-1:0]  opcode,
  input logic [CW_W-1:0]   ctrl_pins,
  input logic [RING_W-1:0] ring,
  input uaddr_t            upc_q,
  input uaddr_t            map_addr,
  input uaddr_t            jump_addr,
  input nsel_e             nsel_w
);

  logic rst_d = 1'b0;
  always @(posedge clk) begin
    // R1
    if (rst_d) reset_idle_chk: assert (ctrl_pins == IDLE_PINS && ring == '0)
      else $error("reset did not idle the control pins");
    rst_d <= rst;
  end

  // R4
  bus_single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ctl_from_pins(ctrl_pins) & DRIVE_MASK) <= 1);

  // R3
  fetch_step1_chk: assert property (@(posedge clk) disable iff (rst)
    ring == RING_W'(1) |-> ctl_from_pins(ctrl_pins) == (S_PC_DRV | S_MAR_LD));

  // R3
  fetch_step3_chk: assert property (@(posedge clk) disable iff (rst)
    ring == RING_W'(4) |-> ctl_from_pins(ctrl_pins) == S_PC_INC && nsel_w == NS_MAP);

  // R7
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    nsel_w == NS_INC |=> upc_q == $past(upc_q) + uaddr_t'(1));

  // R7
  return_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    nsel_w == NS_RET |=> upc_q == A_FETCH && ring == RING_W'(1));

  // R5
  map_load_chk: assert property (@(posedge clk) disable iff (rst)
    nsel_w == NS_MAP |=> upc_q == $past(map_addr));

  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    nsel_w == NS_JMP |=> upc_q == $past(jump_addr));

  // R6
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ring));

  // R6
  ring_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (nsel_w != NS_RET && ring != '0 && !ring[RING_W-1]) |=> ring == ($past(ring) << 1));

  // R6
  ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nsel_w != NS_RET && ring[RING_W-1]) |=> $stable(ring));

  // R10
  undef_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (nsel_w == NS_MAP && !op_defined(opcode)) |=>
      ctrl_pins == IDLE_PINS && nsel_w == NS_RET);

endmodule

bind ctl_sequencer ctl_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .ctrl_pins (ctrl_pins),
  .ring      (ring),
  .upc_q     (upc_q),
  .map_addr  (map_addr),
  .jump_addr (jump_addr),
  .nsel_w    (nsel_w)
);

// File: tb/ctl_sequencer_bench.sv
`timescale 1ns/1ps
module ctl_sequencer_bench;

  // bench's own view of the pin layout (R2)
  localparam logic [12:0] IDLE = 13'h0C7E;
  localparam int PCINC = 0, PCDRV = 1, MARLD = 2, MEMDRV = 3, IRLD = 4, IRDRV = 5,
                 ACCLD = 6, ACCDRV = 7, SUB = 8, ALUDRV = 9, BLD = 10, OUTLD = 11,
                 HALT = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode;
  logic [12:0] ctrl_pins;
  logic [5:0]  ring;

  always #2.5 clk = ~clk;

  ctl_sequencer u_ctl_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .ctrl_pins(ctrl_pins), .ring(ring)
  );

  // datapath model
  logic [7:0] mem [16];
  logic [3:0] pc, mar;
  logic [7:0] ir, acc, breg, bus;
  logic [7:0] out_log [8];
  int n_out, cyc, n_start, bus_viol;
  int starts [16];
  logic [12:0] tr_pins [64];
  logic [5:0]  tr_ring [64];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  assign opcode = ir[7:4];

  function automatic logic [12:0] pins(input logic [12:0] asserted);
    return asserted ^ IDLE;
  endfunction

  function automatic logic [12:0] b(input int i);
    return 13'(1) << i;
  endfunction

  always @(negedge clk) begin
    logic [12:0] c;
    int nd;
    c = ctrl_pins ^ IDLE;
    if (rst) begin
      pc = 0; mar = 0; ir = 8'h00; acc = 0; breg = 0;
      n_out = 0; cyc = 0; n_start = 0; bus_viol = 0;
    end else begin
      nd = int'(c[PCDRV]) + int'(c[MEMDRV]) + int'(c[IRDRV]) + int'(c[ACCDRV]) + int'(c[ALUDRV]);
      if (nd > 1) bus_viol++;
      if (c[PCDRV])       bus = {4'h0, pc};
      else if (c[MEMDRV]) bus = mem[mar];
      else if (c[IRDRV])  bus = {4'h0, ir[3:0]};
      else if (c[ACCDRV]) bus = acc;
      else if (c[ALUDRV]) bus = c[SUB] ? acc - breg : acc + breg;
      else                bus = 8'h00;
      if (c[MARLD]) mar = bus[3:0];
      if (c[IRLD])  ir = bus;
      if (c[ACCLD]) acc = bus;
      if (c[BLD])   breg = bus;
      if (c[PCINC]) pc = pc + 4'd1;
      if (c[OUTLD] && n_out < 8) begin out_log[n_out] = bus; n_out++; end
      if (ring == 6'b000001 && n_start < 16) begin starts[n_start] = cyc; n_start++; end
      if (cyc < 64) begin tr_pins[cyc] = ctrl_pins; tr_ring[cyc] = ring; end
      cyc++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_rst(input logic v);
    @(negedge clk); #1 rst = v;
  endtask

  task automatic t_reset_idle;
    set_rst(1'b1);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "pins in reset", 32'(ctrl_pins), 32'(IDLE));
    chk("R1", "ring in reset", 32'(ring), 32'h0);
    chk("R2", "no signal asserted in reset", 32'(ctrl_pins ^ IDLE), 32'h0);
  endtask

  task automatic t_fetch;
    chk("R3", "fetch step 1", 32'(tr_pins[0]), 32'(pins(b(PCDRV) | b(MARLD))));
    chk("R3", "fetch step 2", 32'(tr_pins[1]), 32'(pins(b(MEMDRV) | b(IRLD))));
    chk("R3", "fetch step 3", 32'(tr_pins[2]), 32'(pins(b(PCINC))));
    chk("R1", "first ring after release", 32'(tr_ring[0]), 32'h1);
  endtask

  task automatic t_routines;
    chk("R5", "load step 1", 32'(tr_pins[3]), 32'(pins(b(IRDRV) | b(MARLD))));
    chk("R5", "load step 2", 32'(tr_pins[4]), 32'(pins(b(MEMDRV) | b(ACCLD))));
    chk("R5", "load step 3", 32'(tr_pins[5]), 32'(IDLE));
    chk("R5", "add step 2", 32'(tr_pins[10]), 32'(pins(b(MEMDRV) | b(BLD))));
    chk("R5", "add step 3", 32'(tr_pins[11]), 32'(pins(b(ALUDRV) | b(ACCLD))));
    chk("R5", "sub step 3", 32'(tr_pins[22]), 32'(pins(b(ALUDRV) | b(SUB) | b(ACCLD))));
    chk("R7", "start of add", 32'(starts[1]), 32'd6);
    chk("R7", "start of output", 32'(starts[2]), 32'd12);
    chk("R7", "start after sub", 32'(starts[4]), 32'd23);
  endtask

  task automatic t_jump;
    bit halted = 1'b0;
    for (int i = 12; i < 32; i++) if (tr_pins[i][HALT]) halted = 1'b1;
    chk("R8", "halt during output", 32'(halted), 32'h0);
    chk("R8", "output step 1", 32'(tr_pins[15]), 32'(pins(b(ACCDRV) | b(OUTLD))));
    chk("R8", "output last step", 32'(tr_pins[16]), 32'(IDLE));
    chk("R8", "start after output", 32'(starts[3]), 32'd17);
    chk("R8", "outputs captured", 32'(n_out), 32'd2);
    chk("R8", "first output value", 32'(out_log[0]), 32'd12);
    chk("R8", "second output value", 32'(out_log[1]), 32'd9);
  endtask

  task automatic t_undef;
    chk("R10", "undefined step", 32'(tr_pins[26]), 32'(IDLE));
    chk("R10", "ring in undefined step", 32'(tr_ring[26]), 32'h8);
    chk("R10", "start after undefined", 32'(starts[5]), 32'd27);
  endtask

  task automatic t_halt;
    int bad = 0;
    for (int i = 35; i < 64; i++) if (!tr_pins[i][HALT]) bad++;
    chk("R9", "cycles without halt", 32'(bad), 32'd0);
    chk("R9", "halt fetch start", 32'(starts[6]), 32'd32);
    chk("R9", "no fetch after halt", 32'(n_start), 32'd7);
    chk("R9", "halt pins", 32'(tr_pins[40]), 32'(pins(b(HALT))));
  endtask

  task automatic t_ring;
    int bad = 0;
    for (int i = 0; i < 6; i++)
      if (tr_ring[i] != 6'(1 << i)) bad++;
    chk("R6", "ring sequence of load", 32'(bad), 32'd0);
    chk("R6", "ring at restart", 32'(tr_ring[6]), 32'h1);
    chk("R6", "ring after jump", 32'(tr_ring[16]), 32'h10);
    chk("R6", "ring held at top", 32'(tr_ring[60]), 32'h20);
    chk("R6", "ring at top", 32'(tr_ring[37]), 32'h20);
  endtask

  task automatic t_bus;
    chk("R4", "cycles with two drivers", 32'(bus_viol), 32'd0);
  endtask

  task automatic t_mid_reset;
    set_rst(1'b0);
    repeat (5) @(negedge clk);
    #1 rst = 1'b1;
    @(negedge clk); #1;
    chk("R1", "pins after mid reset", 32'(ctrl_pins), 32'(IDLE));
    chk("R1", "ring after mid reset", 32'(ring), 32'h0);
    rst = 1'b0;
    repeat (22) @(negedge clk);
    #1;
    chk("R1", "restart fetch step 1", 32'(tr_pins[0]), 32'(pins(b(PCDRV) | b(MARLD))));
    chk("R1", "restart ring", 32'(tr_ring[0]), 32'h1);
    chk("R1", "output after restart", 32'(out_log[0]), 32'd12);
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    mem[0] = 8'h09; mem[1] = 8'h1A; mem[2] = 8'hE0; mem[3] = 8'h2B;
    mem[4] = 8'h70; mem[5] = 8'hE0; mem[6] = 8'hF0;
    mem[9] = 8'h05; mem[10] = 8'h07; mem[11] = 8'h03;
    t_reset_idle;
    set_rst(1'b0);
    repeat (64) @(negedge clk);
    #1;
    t_fetch;
    t_routines;
    t_jump;
    t_undef;
    t_halt;
    t_ring;
    t_bus;
    t_mid_reset;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule